// File: doc/BRIEF.md
# Terminal Line Input Filter

This block sits between a UART receiver and a command parser. Received bytes enter as a valid/ready stream. The block folds the usual line-ending conventions into one end-of-line event. It applies backspace-style editing to an internal line buffer. It also produces the bytes that a UART transmitter should echo back to the terminal. When a line ends, the block pulses a done strobe and reports the character count. The parser then reads the stored characters through a combinational read port.

The echo output is a valid/ready stream. Once `echo_valid` rises, `echo_data` holds still until the transmitter takes the byte with `echo_ready`. The block takes a new input byte only when no echo byte is waiting. `in_ready` therefore drops as soon as an accepted byte produces any echo, and it rises again once the last byte of that echo has been taken. Back-pressure on the echo side thus flows straight through to the receive side. The buffer depth `DEPTH` must be a power of two and at least 2. One entry is kept for the terminating zero, so a line holds at most `DEPTH-1` characters.

Top module: `rx_line_editor`

## Requirements
- R1: After reset, `in_ready` is 1, `echo_valid` is 0, `line_done` is 0 and `line_len` is 0.
- R2: A byte 0x0A that arrives directly after an accepted byte 0x0D is discarded with no echo and no line end. The previous-byte register updates on every accepted byte, dropped ones included, so 0x0D 0x0A 0x0A ends two lines.
- R3: A byte 0x0D ends the line, and so does a byte 0x0A that is not dropped. The sequences CR, LF and CR-LF therefore each give exactly one end of line.
- R4: One cycle after an end-of-line byte is accepted, `line_done` is high for exactly one cycle and `line_len` equals the number of characters stored. The character count then returns to 0.
- R5: An end of line echoes 0x0D followed by 0x0A, so every echoed 0x0A is preceded by an echoed 0x0D.
- R6: Bytes 0x08 and 0x7F both mean delete. On a line that is not empty, a delete removes the last character and echoes 0x08, 0x20, 0x08 in that order.
- R7: A delete on an empty line echoes nothing and changes nothing.
- R8: Every other byte is stored at the index equal to the current count, which then increments. The byte is echoed once, unchanged.
- R9: When `DEPTH-1` characters are stored, further ordinary bytes are discarded without echo. Delete and end of line still work.
- R10: `echo_valid` holds, with `echo_data` stable, until `echo_ready` is seen. `in_ready` is 0 whenever an echo byte is pending.
- R11: After a line ends, `line_rd_data` shows the stored character for each index below `line_len` and 0x00 at index `line_len`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Received byte present |
| in_data | input | 8 | Received byte |
| in_ready | output | 1 | Block accepts the byte this cycle |
| echo_valid | output | 1 | Echo byte present |
| echo_data | output | 8 | Echo byte for the transmitter |
| echo_ready | input | 1 | Transmitter takes the echo byte |
| line_done | output | 1 | One-cycle pulse at end of line |
| line_len | output | log2(DEPTH) | Character count of the finished line |
| line_rd_addr | input | log2(DEPTH) | Line buffer read index |
| line_rd_data | output | 8 | Line buffer byte at the read index |

## Verification
The bench sends nearly every byte value as an ordinary character. It ends lines in turn with CR, LF and CR-LF, and it puts the echo side under random back-pressure. A design that treats every LF as a line end would report an empty second line after CR-LF. A design that forgets to update the previous byte on a dropped LF would swallow the line end of CR LF LF. The bench also deletes on empty and full lines and overfills the buffer. A wrong underflow guard would wrap the count and echo a spurious erase. A wrong capacity limit would overwrite the terminator slot or echo bytes that were never stored.

// File: rtl/lef_pkg.sv
package lef_pkg;
  localparam logic [7:0] CH_NUL = 8'h00;
  localparam logic [7:0] CH_BS  = 8'h08;
  localparam logic [7:0] CH_LF  = 8'h0A;
  localparam logic [7:0] CH_CR  = 8'h0D;
  localparam logic [7:0] CH_SP  = 8'h20;
  localparam logic [7:0] CH_DEL = 8'h7F;

  typedef enum logic [1:0] {
    K_CHAR  = 2'd0,
    K_EOL   = 2'd1,
    K_ERASE = 2'd2,
    K_SKIP  = 2'd3
  } kind_t;

  typedef logic [2:0][7:0] echo_seq_t;
endpackage

// File: rtl/lef_classify.sv
module lef_classify
  import lef_pkg::*;
(
  input  logic [7:0] byte_i,
  input  logic [7:0] prev_i,
  output kind_t      kind_o
);
  always_comb begin
    if (byte_i == CH_LF && prev_i == CH_CR)
      kind_o = K_SKIP;
    else if (byte_i == CH_CR || byte_i == CH_LF)
      kind_o = K_EOL;
    else if (byte_i == CH_BS || byte_i == CH_DEL)
      kind_o = K_ERASE;
    else
      kind_o = K_CHAR;
  end
endmodule

// File: rtl/lef_line_store.sv
module lef_line_store #(
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
    end else if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/lef_echo_seq.sv
module lef_echo_seq
  import lef_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load,
  input  logic [1:0] load_n,
  input  echo_seq_t load_b,
  input  logic      ready_i,
  output logic      valid_o,
  output logic [7:0] data_o,
  output logic      busy_o
);
  logic [1:0] cnt_q;
  echo_seq_t  q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= 2'd0;
      q     <= '0;
    end else if (load) begin
      cnt_q <= load_n;
      q     <= load_b;
    end else if (cnt_q != 2'd0 && ready_i) begin
      cnt_q <= cnt_q - 2'd1;
      q     <= {8'h00, q[2], q[1]};
    end
  end

  assign valid_o = (cnt_q != 2'd0);
  assign busy_o  = valid_o;
  assign data_o  = q[0];
endmodule

// File: rtl/rx_line_editor.sv
module rx_line_editor
  import lef_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  output logic          in_ready,
  output logic          echo_valid,
  output logic [7:0]    echo_data,
  input  logic          echo_ready,
  output logic          line_done,
  output logic [AW-1:0] line_len,
  input  logic [AW-1:0] line_rd_addr,
  output logic [7:0]    line_rd_data
);
  localparam logic [AW-1:0] MAXC = AW'(DEPTH - 1);

  logic [7:0]    prev_q;
  logic [AW-1:0] count_q, count_d;
  logic          done_q;
  logic [AW-1:0] len_q;
  logic          accept, busy;
  kind_t         kind;
  logic          wr_en;
  logic [7:0]    wr_data;
  logic [1:0]    seq_n;
  echo_seq_t     seq_b;

  assign in_ready = ~busy;
  assign accept   = in_valid & in_ready;

  lef_classify u_cls (
    .byte_i (in_data),
    .prev_i (prev_q),
    .kind_o (kind)
  );

  always_comb begin
    wr_en   = 1'b0;
    wr_data = in_data;
    seq_n   = 2'd0;
    seq_b   = '0;
    count_d = count_q;
    case (kind)
      K_EOL: begin
        wr_en    = 1'b1;
        wr_data  = CH_NUL;
        seq_n    = 2'd2;
        seq_b[0] = CH_CR;
        seq_b[1] = CH_LF;
        count_d  = '0;
      end
      K_ERASE: begin
        if (count_q != '0) begin
          seq_n    = 2'd3;
          seq_b[0] = CH_BS;
          seq_b[1] = CH_SP;
          seq_b[2] = CH_BS;
          count_d  = count_q - 1'b1;
        end
      end
      K_CHAR: begin
        if (count_q != MAXC) begin
          wr_en    = 1'b1;
          seq_n    = 2'd1;
          seq_b[0] = in_data;
          count_d  = count_q + 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q  <= 8'h00;
      count_q <= '0;
      done_q  <= 1'b0;
      len_q   <= '0;
    end else begin
      done_q <= accept && (kind == K_EOL);
      if (accept) begin
        prev_q  <= in_data;
        count_q <= count_d;
        if (kind == K_EOL) len_q <= count_q;
      end
    end
  end

  lef_line_store #(.DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (accept & wr_en),
    .wr_addr (count_q),
    .wr_data (wr_data),
    .rd_addr (line_rd_addr),
    .rd_data (line_rd_data)
  );

  lef_echo_seq u_echo (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .load_n  (seq_n),
    .load_b  (seq_b),
    .ready_i (echo_ready),
    .valid_o (echo_valid),
    .data_o  (echo_data),
    .busy_o  (busy)
  );

  assign line_done = done_q;
  assign line_len  = len_q;
endmodule

// File: rtl/lef_checker.sv
module lef_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic [7:0] in_data,
  input logic       echo_valid,
  input logic       echo_ready,
  input logic [7:0] echo_data,
  input logic       line_done
);
  logic [7:0] last_in;
  logic [7:0] last_echo;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_in   <= 8'h00;
      last_echo <= 8'h00;
    end else begin
      if (in_valid && in_ready) last_in <= in_data;
      if (echo_valid && echo_ready) last_echo <= echo_data;
    end
  end

  AST_IN_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    echo_valid |-> !in_ready); // R10

  AST_ECHO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    echo_valid && !echo_ready |=> echo_valid && $stable(echo_data)); // R10

  AST_CRLF_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_data == 8'h0A && last_in == 8'h0D
    |=> !echo_valid && !line_done); // R2

  AST_EOL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (in_data == 8'h0D || (in_data == 8'h0A && last_in != 8'h0D))
    |=> line_done && echo_valid && echo_data == 8'h0D); // R3

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |=> !line_done); // R4

  AST_LF_AFTER_CR: assert property (@(posedge clk) disable iff (!rst_n)
    echo_valid && echo_ready && echo_data == 8'h0A |-> last_echo == 8'h0D); // R5
endmodule

bind rx_line_editor lef_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_data    (in_data),
  .echo_valid (echo_valid),
  .echo_ready (echo_ready),
  .echo_data  (echo_data),
  .line_done  (line_done)
);

// File: tb/rx_line_editor_test.sv
module rx_line_editor_test;
  localparam int DEPTH = 8;
  localparam int AW = 3;
  localparam int MAXC = DEPTH - 1;
  localparam int LOGN = 4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_ready;
  logic echo_valid;
  logic [7:0] echo_data;
  logic echo_ready = 1'b1;
  logic line_done;
  logic [AW-1:0] line_len;
  logic [AW-1:0] line_rd_addr = '0;
  logic [7:0] line_rd_data;

  always #2 clk = ~clk;

  rx_line_editor #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .echo_valid(echo_valid), .echo_data(echo_data), .echo_ready(echo_ready),
    .line_done(line_done), .line_len(line_len),
    .line_rd_addr(line_rd_addr), .line_rd_data(line_rd_data)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // echo capture with optional random back-pressure
  logic [7:0] got_log [LOGN];
  int got_n = 0;
  logic [7:0] exp_log [LOGN];
  string exp_tag [LOGN];
  int exp_n = 0;
  bit stall_mode = 0;
  logic [7:0] lfsr = 8'h5A;
  int stall_viol = 0;
  int hold_viol = 0;
  bit was_blocked = 0;
  logic [7:0] blocked_data = 8'h00;

  always @(negedge clk) begin
    if (rst_n) begin
      if (was_blocked && (!echo_valid || echo_data != blocked_data)) hold_viol++;
      if (echo_valid && in_ready) stall_viol++;
    end
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    echo_ready = stall_mode ? (lfsr[0] & lfsr[2]) : 1'b1;
    was_blocked = rst_n && echo_valid && !echo_ready;
    blocked_data = echo_data;
    if (rst_n && echo_valid && echo_ready && got_n < LOGN) begin
      got_log[got_n] = echo_data;
      got_n++;
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !finished) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // reference model
  logic [7:0] m_prev = 8'h00;
  int m_cnt = 0;
  logic [7:0] m_buf [DEPTH];
  bit last_discard = 0;

  task automatic push(input logic [7:0] b, input string req);
    exp_log[exp_n] = b;
    exp_tag[exp_n] = req;
    exp_n++;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (echo_valid) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b, input string req);
    bit drop;
    int len;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_data = b;
    @(negedge clk);
    in_valid = 1'b0;
    drop = (b == 8'h0A && m_prev == 8'h0D);
    m_prev = b;
    last_discard = 0;
    if (drop) begin
      chk(line_done == 1'b0, "R2 dropped LF gives no line end", int'(line_done), 0);
    end else if (b == 8'h0D || b == 8'h0A) begin
      chk(line_done == 1'b1, "R3 line end pulse", int'(line_done), 1);
      chk(int'(line_len) == m_cnt, "R4 line length", int'(line_len), m_cnt);
      len = m_cnt;
      push(8'h0D, "R5");
      push(8'h0A, "R5");
      m_cnt = 0;
      @(negedge clk);
      chk(line_done == 1'b0, "R4 single pulse", int'(line_done), 0);
      for (int i = 0; i <= len; i++) begin
        line_rd_addr = AW'(i);
        #0.5;
        chk(line_rd_data == ((i < len) ? m_buf[i] : 8'h00), "R11 read port",
            int'(line_rd_data), (i < len) ? int'(m_buf[i]) : 0);
      end
    end else if (b == 8'h08 || b == 8'h7F) begin
      chk(line_done == 1'b0, "R6 no line end on delete", int'(line_done), 0);
      if (m_cnt > 0) begin
        m_cnt--;
        push(8'h08, "R6");
        push(8'h20, "R6");
        push(8'h08, "R6");
      end
    end else begin
      chk(line_done == 1'b0, "R8 no line end on char", int'(line_done), 0);
      if (m_cnt < MAXC) begin
        m_buf[m_cnt] = b;
        m_cnt++;
        push(b, "R8");
      end else begin
        last_discard = 1;
      end
    end
    wait_idle();
    chk(got_n == exp_n, req, got_n, exp_n);
  endtask

  task automatic end_line(input int k);
    if (k == 0) send(8'h0D, "R3 CR ends line");
    else if (k == 1) send(8'h0A, "R3 LF ends line");
    else begin
      send(8'h0D, "R3 CR-LF ends line");
      send(8'h0A, "R2 LF after CR dropped");
    end
  endtask

  initial begin
    int eol_kind;
    for (int i = 0; i < DEPTH; i++) m_buf[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
    chk(echo_valid == 1'b0, "R1 echo_valid", int'(echo_valid), 0);
    chk(line_done == 1'b0, "R1 line_done", int'(line_done), 0);
    chk(line_len == '0, "R1 line_len", int'(line_len), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // sweep of ordinary byte values, overfilling each line
    eol_kind = 0;
    for (int v = 0; v < 256; v++) begin
      if (v == 'h0D || v == 'h0A || v == 'h08 || v == 'h7F) continue;
      stall_mode = (v >= 128);
      send(8'(v), (m_cnt < MAXC) ? "R8 char echoed" : "R9 full line discards");
      if (last_discard) begin
        end_line(eol_kind);
        eol_kind = (eol_kind + 1) % 3;
      end
    end
    end_line(0);

    // deletes
    stall_mode = 1;
    send(8'h08, "R7 delete on empty line");
    send(8'h7F, "R7 delete on empty line");
    send(8'h61, "R8");
    send(8'h62, "R8");
    send(8'h08, "R6 backspace erases");
    send(8'h7F, "R6 del erases");
    send(8'h7F, "R7 delete after line emptied");
    send(8'h63, "R8");
    send(8'h0D, "R4 one char line");
    send(8'h0A, "R2 LF dropped");

    // full line, then delete and refill
    stall_mode = 0;
    for (int i = 0; i < MAXC; i++) send(8'(8'h30 + i), "R8 fill");
    send(8'h7A, "R9 discarded when full");
    chk(last_discard == 1'b1, "R9 model discard", int'(last_discard), 1);
    send(8'h7F, "R9 delete works when full");
    send(8'h71, "R9 refill after delete");
    send(8'h0A, "R9 line end when full");

    // line-ending combinations
    send(8'h0D, "R3 empty line CR");
    send(8'h0A, "R2 dropped");
    send(8'h0A, "R2 second LF ends line");
    send(8'h0A, "R3 LF then");
    send(8'h0D, "R3 CR ends second line");
    send(8'h0D, "R3 CR CR two lines");

    wait_idle();
    chk(got_n == exp_n, "R5 total echo count", got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n; i++)
      chk(got_log[i] == exp_log[i], exp_tag[i], int'(got_log[i]), int'(exp_log[i]));
    chk(stall_viol == 0, "R10 input stalled while echo pending", stall_viol, 0);
    chk(hold_viol == 0, "R10 echo held under back-pressure", hold_viol, 0);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule